// File: doc/BRIEF.md
# Reset-latched operating mode and on-chip memory select

This block sets the operating mode of a small microcontroller from two mode-select pins and decodes a 16-bit address bus into chip-select enables for its on-chip memories. While reset is held, the pins are captured on every clock, so the value captured on the last clock edge of reset becomes the operating mode. After reset is released the mode stays frozen, whatever happens on the pins. Two control bits are derived from the latched mode: a special-mode flag and a mode-A flag.

The latched mode decides which memories respond. A 256-byte bootstrap ROM page is visible only in bootstrap mode. A main ROM at the top of the map is forced on in the two modes that have no external bus, and in the other two modes it follows a configuration enable. An EEPROM window is built in one of two variants. The fixed variant is a 512-byte window. The remappable variant is a 2-Kbyte window that a 4-bit configuration base places within any 4-Kbyte block. Where windows overlap, a fixed priority leaves at most one select active.

The block also drives an active-low load-instruction strobe. The strobe follows the CPU's first-cycle-of-instruction indication, and it is held inactive during reset.

Top module: `opmode_memsel`

## Requirements
- R1: The mode output equals {mode_b_pin, mode_a_pin} as sampled on the last rising clock edge at which rst_n was low. The encoding is 00 bootstrap, 01 test, 10 single-chip and 11 expanded.
- R2: While rst_n is high, changes on mode_b_pin and mode_a_pin have no effect on mode, smod or mda.
- R3: smod is the inverse of the latched mode bit 1, and mda equals the latched mode bit 0.
- R4: boot_sel is 1 only in bootstrap mode (00), and only for addresses 0xBF00 through 0xBFFF.
- R5: In test (01) and expanded (11) modes, the main ROM region 0xE000 through 0xFFFF selects rom_sel only when rom_cfg_en is 1.
- R6: In bootstrap (00) and single-chip (10) modes, the main ROM region selects rom_sel whatever the value of rom_cfg_en.
- R7: With EE_REMAP=0, eep_sel covers 0xB600 through 0xB7FF, and ee_base has no effect.
- R8: With EE_REMAP=1, eep_sel covers every address whose bits [15:12] equal ee_base and whose bit 11 is 1. With ee_base=0xF this is 0xF800 through 0xFFFF.
- R9: Priority is boot_sel over eep_sel over rom_sel, and at most one select is 1 for any address.
- R10: lir_n is 0 exactly when rst_n is 1 and insn_first is 1. During reset lir_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; pins are sampled while low |
| mode_b_pin | input | 1 | Mode-select pin B |
| mode_a_pin | input | 1 | Mode-select pin A |
| rom_cfg_en | input | 1 | Configuration enable for the main ROM in bus modes |
| ee_base | input | 4 | EEPROM 4-Kbyte block number (remappable variant) |
| addr | input | 16 | CPU address |
| insn_first | input | 1 | High during the first cycle of each instruction |
| mode | output | 2 | Latched operating mode |
| smod | output | 1 | Special-mode flag |
| mda | output | 1 | Mode-A flag |
| boot_sel | output | 1 | Bootstrap ROM select |
| eep_sel | output | 1 | EEPROM select |
| rom_sel | output | 1 | Main ROM select |
| lir_n | output | 1 | Active-low load-instruction strobe |

## Verification
The hardest situation to reach is a pin change on the very last edge of reset. The latched value must come from that edge and not from earlier ones. The bench therefore holds decoy pin values for most of reset, switches to the intended values for exactly one edge before release, and then toggles the pins every cycle after release.

Overlaps between windows appear only for particular base values. To reach them, the full address space is swept in every mode with ee_base and rom_cfg_en derived from the address bits. This lands the remapped window on both the bootstrap page and the ROM region.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
    typedef enum logic [1:0] {
        MODE_BOOT   = 2'b00,
        MODE_TEST   = 2'b01,
        MODE_SINGLE = 2'b10,
        MODE_EXPAND = 2'b11
    } opmode_e;

    typedef struct packed {
        opmode_e mode;
        logic    smod;
        logic    mda;
    } latch_state_t;

    typedef struct packed {
        logic boot;
        logic eep;
        logic rom;
    } memsel_t;
endpackage

// File: rtl/mode_latch.sv
module mode_latch
    import opmode_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    mode_b_pin,
    input  logic    mode_a_pin,
    output opmode_e mode_q,
    output logic    smod_q,
    output logic    mda_q
);
    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.mode = opmode_e'({mode_b_pin, mode_a_pin});
            st_d.smod = ~mode_b_pin;
            st_d.mda  = mode_a_pin;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode_q = st_q.mode;
    assign smod_q = st_q.smod;
    assign mda_q  = st_q.mda;

    // Frozen once reset has been released
    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(mode_q) && $stable(smod_q) && $stable(mda_q)));

    // First cycle out of reset shows the pins of the last reset edge
    assert_mode_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_q == opmode_e'($past({mode_b_pin, mode_a_pin}))));
endmodule

// File: rtl/window_decode.sv
module window_decode
    import opmode_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int BOOT_BASE      = 'hBF00,
    parameter int BOOT_BYTES     = 256,
    parameter int ROM_BYTES      = 8192,
    parameter int EE_REMAP       = 1,
    parameter int EE_FIX_BASE    = 'hB600,
    parameter int EE_FIX_BYTES   = 512,
    parameter int EE_BLOCK_BYTES = 4096,
    parameter int EE_WIN_BYTES   = 2048,
    localparam int EE_SEL_W      = ADDR_W - $clog2(EE_BLOCK_BYTES)
)(
    input  logic [ADDR_W-1:0]   addr,
    input  logic [EE_SEL_W-1:0] ee_base,
    output memsel_t             hit
);
    localparam int BOOT_LSB = $clog2(BOOT_BYTES);
    localparam int ROM_LSB  = $clog2(ROM_BYTES);
    localparam int FIX_LSB  = $clog2(EE_FIX_BYTES);
    localparam int BLK_LSB  = $clog2(EE_BLOCK_BYTES);
    localparam int WIN_LSB  = $clog2(EE_WIN_BYTES);
    localparam logic [ADDR_W-1:0] BOOT_ADDR = ADDR_W'(BOOT_BASE);
    localparam logic [ADDR_W-1:0] FIX_ADDR  = ADDR_W'(EE_FIX_BASE);

    logic fix_hit, remap_hit;

    always_comb begin
        hit      = '0;
        hit.boot = (addr[ADDR_W-1:BOOT_LSB] == BOOT_ADDR[ADDR_W-1:BOOT_LSB]);
        hit.rom  = &addr[ADDR_W-1:ROM_LSB];
        fix_hit  = (addr[ADDR_W-1:FIX_LSB] == FIX_ADDR[ADDR_W-1:FIX_LSB]);
        // window occupies the top part of the selected block
        remap_hit = (addr[ADDR_W-1:BLK_LSB] == ee_base) && (&addr[BLK_LSB-1:WIN_LSB]);
        hit.eep  = (EE_REMAP != 0) ? remap_hit : fix_hit;
    end
endmodule

// File: rtl/sel_priority.sv
module sel_priority
    import opmode_pkg::*;
(
    input  opmode_e mode,
    input  logic    rom_cfg_en,
    input  memsel_t hit,
    output memsel_t sel
);
    logic boot_ok, rom_ok;

    always_comb begin
        boot_ok = (mode == MODE_BOOT);
        // bus modes (mode bit 0 set) honour the configuration enable
        rom_ok  = (mode == MODE_BOOT) || (mode == MODE_SINGLE) || rom_cfg_en;
        sel      = '0;
        sel.boot = hit.boot && boot_ok;
        sel.eep  = hit.eep && !sel.boot;
        sel.rom  = hit.rom && rom_ok && !sel.boot && !sel.eep;
    end
endmodule

// File: rtl/lir_strobe.sv
module lir_strobe (
    input  logic rst_n,
    input  logic insn_first,
    output logic lir_n
);
    always_comb begin
        lir_n = 1'b1;
        if (rst_n && insn_first) lir_n = 1'b0;
    end
endmodule

// File: rtl/opmode_memsel.sv
module opmode_memsel
    import opmode_pkg::*;
#(
    parameter int EE_REMAP = 1
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_b_pin,
    input  logic        mode_a_pin,
    input  logic        rom_cfg_en,
    input  logic [3:0]  ee_base,
    input  logic [15:0] addr,
    input  logic        insn_first,
    output logic [1:0]  mode,
    output logic        smod,
    output logic        mda,
    output logic        boot_sel,
    output logic        eep_sel,
    output logic        rom_sel,
    output logic        lir_n
);
    opmode_e mode_q;
    memsel_t hit, sel;

    mode_latch u_latch (
        .clk(clk), .rst_n(rst_n),
        .mode_b_pin(mode_b_pin), .mode_a_pin(mode_a_pin),
        .mode_q(mode_q), .smod_q(smod), .mda_q(mda)
    );

    window_decode #(.ADDR_W(16), .EE_REMAP(EE_REMAP)) u_dec (
        .addr(addr), .ee_base(ee_base), .hit(hit)
    );

    sel_priority u_pri (
        .mode(mode_q), .rom_cfg_en(rom_cfg_en), .hit(hit), .sel(sel)
    );

    lir_strobe u_lir (.rst_n(rst_n), .insn_first(insn_first), .lir_n(lir_n));

    assign mode     = mode_q;
    assign boot_sel = sel.boot;
    assign eep_sel  = sel.eep;
    assign rom_sel  = sel.rom;

    assert_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smod == ~mode[1]) && (mda == mode[0]));

    assert_boot_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        boot_sel |-> (mode == 2'b00 && addr >= 16'hBF00 && addr <= 16'hBFFF));

    assert_rom_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mda && !rom_cfg_en) |-> !rom_sel);

    assert_rom_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mda && addr >= 16'hE000 && !boot_sel && !eep_sel) |-> rom_sel);

    assert_one_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({boot_sel, eep_sel, rom_sel}));

    assert_lir_idle_R10: assert property (@(posedge clk)
        !rst_n |-> lir_n);
endmodule

// File: tb/sim_opmode_memsel.sv
`timescale 1ns/1ps
module sim_opmode_memsel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mb = 1'b0, ma = 1'b0, cfg = 1'b0, insn = 1'b0;
    logic [3:0]  ee = 4'h0;
    logic [15:0] addr = 16'h0;
    logic [1:0]  mode0, mode1;
    logic        smod0, mda0, bs0, es0, rs0, lir0;
    logic        smod1, mda1, bs1, es1, rs1, lir1;
    int          n_chk = 0, n_fail = 0, n_print = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    opmode_memsel #(.EE_REMAP(1)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_b_pin(mb), .mode_a_pin(ma),
        .rom_cfg_en(cfg), .ee_base(ee), .addr(addr), .insn_first(insn),
        .mode(mode0), .smod(smod0), .mda(mda0), .boot_sel(bs0),
        .eep_sel(es0), .rom_sel(rs0), .lir_n(lir0));

    opmode_memsel #(.EE_REMAP(0)) u1 (
        .clk(clk), .rst_n(rst_n), .mode_b_pin(mb), .mode_a_pin(ma),
        .rom_cfg_en(cfg), .ee_base(ee), .addr(addr), .insn_first(insn),
        .mode(mode1), .smod(smod1), .mda(mda1), .boot_sel(bs1),
        .eep_sel(es1), .rom_sel(rs1), .lir_n(lir1));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            if (n_print < 40) begin
                n_print++;
                $display("FAIL %s: actual %0h expected %0h (addr %h mode %0d cfg %0b ee %h)",
                         req, act, exp, addr, mode0, cfg, ee);
            end
        end
    endtask

    // expected selects {boot,eep,rom} from the requirements
    function automatic logic [2:0] model(input logic [1:0] m, input logic [15:0] a,
                                         input logic c, input logic [3:0] e, input bit remap);
        logic b, ep, r;
        b  = (m == 2'b00) && (a >= 16'hBF00) && (a <= 16'hBFFF);
        ep = remap ? ((a[15:12] == e) && a[11]) : ((a >= 16'hB600) && (a <= 16'hB7FF));
        r  = (a >= 16'hE000) && ((m == 2'b00) || (m == 2'b10) || c);
        if (b) return 3'b100;
        if (ep) return 3'b010;
        return {2'b00, r};
    endfunction

    task automatic check_sel(input logic [2:0] act, input logic [2:0] exp, input bit remap);
        string req;
        if ($countones(act) > 1)       req = "R9";
        else if (act[2] != exp[2])     req = "R4";
        else if (act[1] != exp[1])     req = remap ? "R8" : "R7";
        else if (mode0[0])             req = "R5";
        else                           req = "R6";
        check(req, act, exp);
    endtask

    task automatic enter_mode(input logic [1:0] m);
        rst_n = 1'b0;
        insn = 1'b1;
        {mb, ma} = ~m;                      // decoy values early in reset
        repeat (3) @(negedge clk);
        check("R10", {lir0, lir1}, 2'b11);  // held inactive in reset
        {mb, ma} = m;                       // visible on the last reset edge only
        @(negedge clk);
        rst_n = 1'b1;
        {mb, ma} = ~m;
        @(negedge clk);
        check("R1", mode0, m);
        check("R1", mode1, m);
        check("R3", {smod0, mda0}, {~m[1], m[0]});
        for (int k = 0; k < 6; k++) begin
            {mb, ma} = 2'(k);
            @(negedge clk);
            check("R2", {mode0, smod0, mda0, mode1}, {m, ~m[1], m[0], m});
        end
        insn = 1'b0;
        #0.5 check("R10", lir0, 1);
        insn = 1'b1;
        #0.5 check("R10", lir0, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        check("R10", lir0, 1);
        for (int m = 0; m < 4; m++) begin
            enter_mode(2'(m));
            // corner points: remap default, fixed window, bootstrap page
            ee = 4'hF; cfg = 1'b0;
            addr = 16'hF800; #0.5 check("R8", es0, 1);
            addr = 16'hF7FF; #0.5 check("R8", es0, 0);
            addr = 16'hB600; #0.5 check("R7", es1, 1);
            addr = 16'hB800; #0.5 check("R7", es1, 0);
            addr = 16'hBF00; #0.5 check("R4", bs0, (m == 0) ? 1 : 0);
            addr = 16'hE000; #0.5 check(m[0] ? "R5" : "R6", rs1, m[0] ? 0 : 1);
            for (int a = 0; a < 65536; a++) begin
                addr = 16'(a);
                cfg  = addr[4];
                ee   = addr[15:12] ^ addr[3:0];
                #0.5;
                check_sel({bs0, es0, rs0}, model(2'(m), addr, cfg, ee, 1'b1), 1'b1);
                check_sel({bs1, es1, rs1}, model(2'(m), addr, cfg, ee, 1'b0), 1'b0);
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule